// File: doc/BRIEF.md
# Serial Stereo Audio Output Formatter

This block turns parallel stereo samples into a serial audio stream on a set of data lines that share one bit clock and one word-select. Every frame holds two 32-bit-clock slots, left first (word-select low), then right. A two-bit format input picks one of four framings. Three are conventional PCM framings: the standard one-bit-delayed stereo framing, left-justified, and right-justified with a programmable valid width. The fourth passes raw 32-bit IEC60958 subframe words through, least significant bit first.

The master clock comes either from a divider on the system clock or from an external pin, which is synchronized into the system clock domain. The bit clock is the chosen master clock divided by four. Word-select and data change only when the bit clock falls. Sample words, the format and the width are captured once per frame, when the left slot begins, so the frame in flight never changes. A control override puts four static control bits on the data lines. A float request drops the pad drive enable that the pad ring uses to put the serial outputs in high impedance.

Top module: `aud_ser_fmt`

## Requirements
- R1: While reset is asserted, and right after reset is released: bclk_o is 0, ws_o is 1, every sd_o line is 0 and pad_oe_o is 1.
- R2: Format 2'b00 (standard framing): the frame is 64 bit clocks, with the left slot while ws_o is 0 and the right slot while ws_o is 1. Slot bit position p (1..31) carries sample bit 32-p. Position 0 carries bit 0 of the word from the previous slot. For the first left slot after reset, that bit is 0.
- R3: Format 2'b10 (left-justified): slot position p carries sample bit 31-p, so the MSB sits on the same bit clock as the word-select change.
- R4: Format 2'b01 (right-justified) with width W (0..31): positions 32-W..31 carry sample bits W-1..0, so the LSB is on the last bit clock of the slot. All earlier positions are 0, and W=0 gives an all-zero slot.
- R5: Format 2'b11 (raw IEC60958): slot position p carries word bit p, least significant bit first.
- R6: The samples, format and width in use are the values present when the left slot begins. Changes made during a frame take effect at the next frame.
- R7: The bit clock period is exactly four master-clock periods. ws_o and the sd lines change only on a falling edge of bclk_o.
- R8: With mclk_sel_i=0 the master clock is the internal divider (MCLK_HALF system clocks high, MCLK_HALF low). With mclk_sel_i=1 it is mclk_ext_i after synchronization. mclk_o shows the chosen clock.
- R9: While ctrl_en_i=1, sd_o[i] equals ctrl_i[i] in the same cycle, in place of audio data.
- R10: pad_oe_o is the inverse of tristate_i in the same cycle; 0 means the serial pads float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_sel_i | input | 1 | 0 = internal master clock, 1 = external |
| mclk_ext_i | input | 1 | External master clock |
| fmt_i | input | 2 | Framing: 00 standard, 01 right-justified, 10 left-justified, 11 raw |
| rj_width_i | input | 5 | Valid bits in right-justified framing |
| ctrl_en_i | input | 1 | Put control bits on the data lines |
| ctrl_i | input | N_LINES | Control bits, one per data line |
| tristate_i | input | 1 | Float the serial pads |
| left_i | input | N_LINES x 32 | Left sample word per line |
| right_i | input | N_LINES x 32 | Right sample word per line |
| mclk_o | output | 1 | Master clock out |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left |
| sd_o | output | N_LINES | Serial data lines |
| pad_oe_o | output | 1 | Pad drive enable for the serial outputs |

## Verification
The assertions assume that the external master clock stays at each level for at least two system clocks. They also assume that format, width and samples only need to be valid at the left-slot boundary. The stimulus drives an external clock with three system clocks per level. It changes samples and configuration in the right slot, except in one directed case that changes them early in a left slot to exercise R6. The control override and the float request are changed at arbitrary cycles. Frames cut by the override are left out of the frame comparison.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;
  typedef enum logic [1:0] {
    FMT_STD = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_RAW = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_mclk_sel.sv
module aud_mclk_sel #(
  parameter int MCLK_HALF   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic ext_i,
  output logic mclk_o,
  output logic mtick_o
);
  localparam int CW = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;

  logic [CW-1:0]          div_cnt, div_cnt_n;
  logic                   mclk_int, mclk_int_n;
  logic [SYNC_STAGES-1:0] sync_q, sync_n;
  logic                   prev_q, prev_n;
  logic                   mclk_mux;

  always_comb begin
    if (div_cnt == CW'(MCLK_HALF - 1)) begin
      div_cnt_n  = '0;
      mclk_int_n = ~mclk_int;
    end else begin
      div_cnt_n  = div_cnt + CW'(1);
      mclk_int_n = mclk_int;
    end
    sync_n   = {sync_q[SYNC_STAGES-2:0], ext_i};
    mclk_mux = sel_i ? sync_q[SYNC_STAGES-1] : mclk_int;
    prev_n   = mclk_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      mclk_int <= 1'b0;
      sync_q   <= '0;
      prev_q   <= 1'b0;
    end else begin
      div_cnt  <= div_cnt_n;
      mclk_int <= mclk_int_n;
      sync_q   <= sync_n;
      prev_q   <= prev_n;
    end
  end

  assign mclk_o  = mclk_mux;
  assign mtick_o = mclk_mux & ~prev_q;

  // R8: the internal clock holds its level until the divider count expires
  a_r8_int_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != CW'(MCLK_HALF - 1)) |=> $stable(mclk_int));
endmodule

// File: rtl/aud_bclk_div.sv
module aud_bclk_div (
  input  logic clk,
  input  logic rst_n,
  input  logic mtick_i,
  output logic bclk_o,
  output logic fall_o
);
  logic [1:0] ph_q, ph_n;

  always_comb begin
    ph_n = mtick_i ? ph_q + 2'd1 : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 2'd0;
    else        ph_q <= ph_n;
  end

  assign bclk_o = ph_q[1];
  assign fall_o = mtick_i && (ph_q == 2'd3);

  // R7: the bit clock only moves on a master clock rising edge
  a_r7_bclk_on_mtick: assert property (@(posedge clk) disable iff (!rst_n)
    !mtick_i |=> $stable(bclk_o));
endmodule

// File: rtl/aud_frame_ctl.sv
module aud_frame_ctl
  import aud_ser_pkg::*;
#(
  parameter int SLOT_W = 32,
  localparam int IDX_W = $clog2(SLOT_W),
  localparam int POS_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  fmt_e             fmt_i,
  input  logic [IDX_W-1:0] wid_i,
  output logic [POS_W-1:0] npos_o,
  output logic             start_o,
  output fmt_e             fmt_o,
  output logic [IDX_W-1:0] wid_o,
  output logic             ws_o
);
  logic [POS_W-1:0] pos_q, pos_n;
  fmt_e             fmt_q, fmt_n;
  logic [IDX_W-1:0] wid_q, wid_n;
  logic             ws_q, ws_n;
  logic [POS_W-1:0] npos;
  logic             start;

  always_comb begin
    npos  = pos_q + POS_W'(1);
    start = fall_i && (npos == '0);
    pos_n = fall_i ? npos : pos_q;
    ws_n  = fall_i ? npos[POS_W-1] : ws_q;
    fmt_n = start ? fmt_i : fmt_q;
    wid_n = start ? wid_i : wid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '1;
      ws_q  <= 1'b1;
      fmt_q <= FMT_STD;
      wid_q <= IDX_W'(24);
    end else begin
      pos_q <= pos_n;
      ws_q  <= ws_n;
      fmt_q <= fmt_n;
      wid_q <= wid_n;
    end
  end

  assign npos_o  = npos;
  assign start_o = start;
  assign fmt_o   = fmt_n;
  assign wid_o   = wid_n;
  assign ws_o    = ws_q;

  // R2: every frame opens with the left slot
  a_r2_left_first: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ws_o);
endmodule

// File: rtl/aud_lane.sv
module aud_lane
  import aud_ser_pkg::*;
#(
  parameter int SLOT_W = 32,
  localparam int IDX_W = $clog2(SLOT_W),
  localparam int POS_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic [POS_W-1:0]  npos_i,
  input  fmt_e              fmt_i,
  input  logic [IDX_W-1:0]  wid_i,
  input  logic [SLOT_W-1:0] left_i,
  input  logic [SLOT_W-1:0] right_i,
  output logic              sd_o
);
  logic [SLOT_W-1:0] hold_l, hold_l_n, hold_r, hold_r_n;
  logic              sd_q, sd_n;
  logic [SLOT_W-1:0] word;
  logic              prv;
  logic [IDX_W-1:0]  pidx;

  function automatic logic pick_bit(fmt_e f, logic [IDX_W-1:0] w,
                                    logic [SLOT_W-1:0] wd, logic pv,
                                    logic [IDX_W-1:0] p);
    int pi;
    pi = int'(p);
    case (f)
      FMT_STD: pick_bit = (pi == 0) ? pv : wd[IDX_W'(SLOT_W - pi)];
      FMT_LJ:  pick_bit = wd[IDX_W'(SLOT_W - 1 - pi)];
      FMT_RJ:  pick_bit = (pi >= SLOT_W - int'(w)) ? wd[IDX_W'(SLOT_W - 1 - pi)] : 1'b0;
      default: pick_bit = wd[p];
    endcase
  endfunction

  always_comb begin
    pidx     = npos_i[IDX_W-1:0];
    hold_l_n = start_i ? left_i  : hold_l;
    hold_r_n = start_i ? right_i : hold_r;
    if (npos_i[POS_W-1]) begin
      word = hold_r;
      prv  = hold_l[0];
    end else begin
      word = start_i ? left_i : hold_l;
      prv  = hold_r[0];
    end
    sd_n = fall_i ? pick_bit(fmt_i, wid_i, word, prv, pidx) : sd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      sd_q   <= 1'b0;
    end else begin
      hold_l <= hold_l_n;
      hold_r <= hold_r_n;
      sd_q   <= sd_n;
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt
  import aud_ser_pkg::*;
#(
  parameter int N_LINES     = 4,
  parameter int SLOT_W      = 32,
  parameter int MCLK_HALF   = 1,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(SLOT_W),
  localparam int POS_W = IDX_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            mclk_sel_i,
  input  logic                            mclk_ext_i,
  input  logic [1:0]                      fmt_i,
  input  logic [IDX_W-1:0]                rj_width_i,
  input  logic                            ctrl_en_i,
  input  logic [N_LINES-1:0]              ctrl_i,
  input  logic                            tristate_i,
  input  logic [N_LINES-1:0][SLOT_W-1:0]  left_i,
  input  logic [N_LINES-1:0][SLOT_W-1:0]  right_i,
  output logic                            mclk_o,
  output logic                            bclk_o,
  output logic                            ws_o,
  output logic [N_LINES-1:0]              sd_o,
  output logic                            pad_oe_o
);
  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  logic               mtick, fall;
  logic [POS_W-1:0]   npos;
  logic               start;
  fmt_e               fmt_eff;
  logic [IDX_W-1:0]   wid_eff;
  logic [N_LINES-1:0] sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  aud_mclk_sel #(.MCLK_HALF(MCLK_HALF), .SYNC_STAGES(SYNC_STAGES)) u_mclk (
    .clk(clk), .rst_n(rst_n_s), .sel_i(mclk_sel_i), .ext_i(mclk_ext_i),
    .mclk_o(mclk_o), .mtick_o(mtick));

  aud_bclk_div u_bclk (
    .clk(clk), .rst_n(rst_n_s), .mtick_i(mtick), .bclk_o(bclk_o), .fall_o(fall));

  aud_frame_ctl #(.SLOT_W(SLOT_W)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .fall_i(fall), .fmt_i(fmt_e'(fmt_i)),
    .wid_i(rj_width_i), .npos_o(npos), .start_o(start), .fmt_o(fmt_eff),
    .wid_o(wid_eff), .ws_o(ws_o));

  for (genvar g = 0; g < N_LINES; g++) begin : g_lane
    aud_lane #(.SLOT_W(SLOT_W)) u_lane (
      .clk(clk), .rst_n(rst_n_s), .fall_i(fall), .start_i(start),
      .npos_i(npos), .fmt_i(fmt_eff), .wid_i(wid_eff),
      .left_i(left_i[g]), .right_i(right_i[g]), .sd_o(sd_q[g]));
  end

  assign sd_o     = ctrl_en_i ? ctrl_i : sd_q;
  assign pad_oe_o = ~tristate_i;

  // R7: word select moves only together with a falling bit clock
  a_r7_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ws_o != $past(ws_o)) |-> $fell(bclk_o));

  // R7: serial data moves only together with a falling bit clock
  a_r7_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sd_q != $past(sd_q)) |-> $fell(bclk_o));
endmodule

// File: tb/aud_ser_fmt_tb.sv
module aud_ser_fmt_tb;
  logic clk, rst_n, mclk_sel, mclk_ext, ctrl_en, tristate;
  logic [1:0] fmt;
  logic [4:0] width;
  logic [3:0] ctrl;
  logic [3:0][31:0] left_s, right_s;
  logic mclk_o, bclk_o, ws_o, pad_oe;
  logic [3:0] sd_o;

  int total = 0, bad = 0;
  bit done = 0;

  aud_ser_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .mclk_sel_i(mclk_sel), .mclk_ext_i(mclk_ext),
    .fmt_i(fmt), .rj_width_i(width), .ctrl_en_i(ctrl_en), .ctrl_i(ctrl),
    .tristate_i(tristate), .left_i(left_s), .right_i(right_s),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .pad_oe_o(pad_oe));

  initial begin clk = 0; forever #5 clk = ~clk; end
  initial begin mclk_ext = 0; forever #30 mclk_ext = ~mclk_ext; end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic ref_bit(logic [1:0] m, int w, logic [31:0] wd, logic pv, int p);
    case (m)
      2'b00:   return (p == 0) ? pv : wd[32 - p];
      2'b10:   return wd[31 - p];
      2'b01:   return (p >= 32 - w) ? wd[31 - p] : 1'b0;
      default: return wd[p];
    endcase
  endfunction

  function automatic logic [63:0] ref_frame(logic [1:0] m, int w, logic [31:0] l,
                                            logic [31:0] r, logic pv);
    logic [63:0] v;
    for (int p = 0; p < 32; p++) begin
      v[p]      = ref_bit(m, w, l, pv, p);
      v[32 + p] = ref_bit(m, w, r, l[0], p);
    end
    return v;
  endfunction

  // monitor state
  logic prev_bclk, prev_ws, frame_valid, fr_r6, chk_en, per_chk_en, have_prev;
  int mon_pos, frame_no, since;
  logic [3:0][63:0] obs;
  logic [3:0][31:0] fr_l, fr_r;
  logic [1:0] fr_m;
  int fr_w;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_bclk = 0; prev_ws = 1; frame_valid = 0; fr_r6 = 0; have_prev = 0;
      mon_pos = 0; frame_no = 0; since = 0; obs = '0; fr_l = '0; fr_r = '0;
      fr_m = 0; fr_w = 0;
    end else begin
      since++;
      if (prev_bclk && !bclk_o) begin
        if (per_chk_en && have_prev)
          chk(since == (mclk_sel ? 24 : 8), "R7 R8 bclk period", since, mclk_sel ? 24 : 8);
        since = 0; have_prev = 1;
        if (ws_o != prev_ws) begin
          mon_pos = 0;
          if (!ws_o) begin
            if (frame_valid && chk_en) begin
              for (int l = 0; l < 4; l++) begin
                logic [63:0] e;
                string tg;
                e = ref_frame(fr_m, fr_w, fr_l[l], fr_r[l], (l < 4) ? fr_pv[l] : 1'b0);
                tg = fr_r6 ? "R6" : (fr_m == 2'b00) ? "R2" : (fr_m == 2'b10) ? "R3" :
                     (fr_m == 2'b01) ? "R4" : "R5";
                chk(obs[l] == e, tg, obs[l], e);
              end
            end
            fr_r6 = 0;
            frame_valid = chk_en;
            for (int l = 0; l < 4; l++) fr_pv[l] = fr_r[l][0];
            fr_l = left_s; fr_r = right_s; fr_m = fmt; fr_w = int'(width);
            frame_no++;
          end
        end else mon_pos++;
        for (int l = 0; l < 4; l++) obs[l][(ws_o ? 32 : 0) + mon_pos] = sd_o[l];
      end
      prev_bclk = bclk_o; prev_ws = ws_o;
    end
  end
  logic [3:0] fr_pv = '0;

  task automatic set_frame(logic [1:0] m, logic [4:0] w);
    int f0;
    f0 = frame_no;
    while (frame_no == f0) @(posedge clk);
    while (!ws_o) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    fmt = m; width = w;
    for (int l = 0; l < 4; l++) begin left_s[l] = $urandom; right_s[l] = $urandom; end
  endtask

  task automatic wait_frames(int n);
    for (int i = 0; i < n; i++) begin
      int f0;
      f0 = frame_no;
      while (frame_no == f0) @(posedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_n = 0; mclk_sel = 0; ctrl_en = 0; tristate = 0; fmt = 2'b00; width = 5'd24;
    ctrl = 4'h0; left_s = '0; right_s = '0; chk_en = 1; per_chk_en = 1;
    repeat (3) @(negedge clk);
    chk(bclk_o == 0 && ws_o == 1 && sd_o == 0, "R1 in reset", {bclk_o, ws_o, sd_o}, 6'b010000);
    chk(pad_oe == 1, "R1 pad_oe", pad_oe, 1);
    left_s[0] = 32'h8000_0001; right_s[0] = 32'hFFFF_FFFE;
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(bclk_o == 0 && ws_o == 1 && sd_o == 0, "R1 after release", {bclk_o, ws_o, sd_o}, 6'b010000);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      logic m0;
      m0 = mclk_o;
      @(negedge clk);
      chk(mclk_o != m0, "R8 internal mclk toggles", mclk_o, ~m0);
    end
    // directed framings
    set_frame(2'b00, 5'd24);
    left_s[1] = 32'h8000_0001; right_s[1] = 32'h0000_0001;
    set_frame(2'b10, 5'd24);
    set_frame(2'b01, 5'd24);
    set_frame(2'b01, 5'd31);
    set_frame(2'b01, 5'd0);
    set_frame(2'b01, 5'd1);
    set_frame(2'b11, 5'd3);
    set_frame(2'b10, 5'd7);
    // R6: change everything early in a left slot
    wait_frames(1);
    repeat (20) @(posedge clk);
    #1;
    fmt = 2'b11; width = 5'd9; fr_r6 = 1;
    for (int l = 0; l < 4; l++) begin left_s[l] = $urandom; right_s[l] = $urandom; end
    // random frames
    for (int i = 0; i < 30; i++) set_frame(2'($urandom % 4), 5'($urandom % 32));
    // external master clock
    @(posedge clk); #1 per_chk_en = 0; mclk_sel = 1;
    repeat (60) @(posedge clk); #1 have_prev = 0; per_chk_en = 1;
    for (int i = 0; i < 6; i++) set_frame(2'($urandom % 4), 5'($urandom % 32));
    @(posedge clk); #1 per_chk_en = 0; mclk_sel = 0;
    repeat (60) @(posedge clk); #1 have_prev = 0; per_chk_en = 1;
    set_frame(2'b00, 5'd16);
    // R9 control override
    wait_frames(2);
    @(posedge clk); #1 chk_en = 0; frame_valid = 0; ctrl_en = 1; ctrl = 4'hA;
    @(negedge clk); chk(sd_o == 4'hA, "R9 ctrl A", sd_o, 4'hA);
    repeat (37) @(posedge clk); #1 ctrl = 4'h5;
    @(negedge clk); chk(sd_o == 4'h5, "R9 ctrl 5", sd_o, 4'h5);
    repeat (101) @(posedge clk); #1 ctrl = 4'h3;
    @(negedge clk); chk(sd_o == 4'h3, "R9 ctrl 3", sd_o, 4'h3);
    @(posedge clk); #1 ctrl_en = 0; chk_en = 1;
    // R10 float request
    repeat (13) @(posedge clk); #1 tristate = 1;
    @(negedge clk); chk(pad_oe == 0, "R10 float", pad_oe, 0);
    repeat (5) @(posedge clk); #1 tristate = 0;
    @(negedge clk); chk(pad_oe == 1, "R10 drive", pad_oe, 1);
    set_frame(2'b01, 5'd20);
    set_frame(2'b11, 5'd0);
    wait_frames(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule